// File: doc/BRIEF.md
# Manchester Line Encoder with Registered Output

This block turns a serial bit stream into a Manchester-coded line level. It runs from a clock at twice the bit rate, so each bit lasts two clock cycles. The block keeps its own half-bit phase and gives every bit one transition in the middle. A 0 bit is sent high and then low. A 1 bit is sent low and then high.

The coded level is formed by a single XOR of the held data bit and the phase. Data and phase can change on the same edge, so that raw level may glitch. It is therefore captured in a flip-flop before it reaches the pin. By default that flip-flop uses the same rising edge as the rest of the logic, which adds one clock of latency. A parameter moves it to the falling edge, which cuts the added latency to half a clock.

The upstream source supplies bits through `din`. A one-cycle request pulse tells the source when to present the next bit, and that bit is sampled at the rising edge that ends the pulse. While `en` is low the line rests low.

Top module: `manchester_line_enc`

## Requirements
- R1: With `OUT_ON_FALL` = 0, a 0 bit makes `line_o` high for the first of its two cycles and low for the second.
- R2: With `OUT_ON_FALL` = 0, a 1 bit makes `line_o` low for the first of its two cycles and high for the second.
- R3: A bit is sampled from `din` at the rising edge where `en` is 1 and the encoder is idle or in the second half of a bit. Changes of `din` at any other edge do not alter the bit being sent.
- R4: `bit_req_o` is high for exactly one cycle per bit, which is the cycle in which `line_o` shows that bit's first half. The next bit must be valid on `din` at the rising edge that ends this cycle.
- R5: The first bit is sampled at the first rising edge where `en` is 1. Its first half appears on `line_o` one cycle later, and `line_o` is low during that cycle.
- R6: Once `en` is sampled low, `bit_req_o` is 0 from the next cycle onward. `line_o` is 0 from the second cycle onward, and the phase returns to the first half.
- R7: Synchronous reset `rst` clears the phase, the held bit, `line_o` and `bit_req_o` to 0 at the next rising edge.
- R8: A stream sent without gaps keeps exactly one transition in the middle of each bit, with no cycle lost between bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable for encoding; low holds the line idle |
| din | input | 1 | Serial data bit from the source |
| line_o | output | 1 | Registered Manchester line level |
| bit_req_o | output | 1 | Request pulse for the next data bit |

## Verification
Take E0 as the rising edge where `en` is first seen high. Bit i is sampled at edge E0+2i. Its first half shows on `line_o` after edge E0+2i+1, together with `bit_req_o`, and its second half shows after edge E0+2i+2. When `en` falls, the request clears one edge later and the line clears two edges later. Each task changes inputs shortly after a rising edge and samples outputs a quarter period after the edge it expects, so no check depends on the order of processes at the edge.

// File: rtl/mle_pkg.sv
package mle_pkg;

  // Half of a bit period, as tracked by the phase register.
  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;

  // Idle level of the line while the encoder is disabled.
  localparam logic LINE_IDLE = 1'b0;

endpackage

// File: rtl/mle_phase_ctrl.sv
module mle_phase_ctrl
  import mle_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  output logic  run_o,
  output half_e half_o,
  output logic  take_o,
  output logic  req_o
);

  logic  run_q;
  half_e half_q;
  logic  req_q;

  // A new bit starts when enabled and not in the middle of a bit.
  assign take_o = en && (!run_q || (half_q == HALF_SECOND));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      half_q <= HALF_FIRST;
      req_q  <= 1'b0;
    end else if (!en) begin
      run_q  <= 1'b0;
      half_q <= HALF_FIRST;
      req_q  <= 1'b0;
    end else if (take_o) begin
      run_q  <= 1'b1;
      half_q <= HALF_FIRST;
      req_q  <= 1'b0;
    end else begin
      half_q <= HALF_SECOND;
      req_q  <= 1'b1;
    end
  end

  assign run_o  = run_q;
  assign half_o = half_q;
  assign req_o  = req_q;

  // R4: the request never lasts two cycles
  a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  // R6: disabling clears the request and the phase at the next edge
  a_r6_disable_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!req_q && half_q == HALF_FIRST));

  // R8: a running first half always advances to the second half
  a_r8_phase_adv: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && half_q == HALF_FIRST) |=> (half_q == HALF_SECOND && run_q));

endmodule

// File: rtl/mle_bit_hold.sv
module mle_bit_hold
  import mle_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  din,
  input  half_e half,
  output logic  bit_o
);

  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst)       bit_q <= 1'b0;
    else if (take) bit_q <= din;
  end

  assign bit_o = bit_q;

  // R3: the held bit does not move into the second half of a bit
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (half == HALF_SECOND) |-> $stable(bit_q));

endmodule

// File: rtl/mle_line_reg.sv
module mle_line_reg
  import mle_pkg::*;
#(
  parameter bit OUT_ON_FALL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  half_e half,
  input  logic  bit_in,
  output logic  line_o
);

  logic coded;
  logic line_q;

  // XOR of data with the inverted phase: first half carries ~bit, second half bit.
  always_comb begin
    if (run) coded = bit_in ^ ~half;
    else     coded = LINE_IDLE;
  end

  generate
    if (OUT_ON_FALL) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) line_q <= LINE_IDLE;
        else     line_q <= coded;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) line_q <= LINE_IDLE;
        else     line_q <= coded;
      end

      // R1/R2: in the second internal half, the line shows the first-half level
      a_r1_first_half: assert property (@(posedge clk) disable iff (rst)
        (run && half == HALF_SECOND) |-> (line_q == !bit_in));
    end
  endgenerate

  assign line_o = line_q;

endmodule

// File: rtl/manchester_line_enc.sv
module manchester_line_enc
  import mle_pkg::*;
#(
  parameter bit OUT_ON_FALL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic line_o,
  output logic bit_req_o
);

  logic  run;
  half_e half;
  logic  take;
  logic  held_bit;

  mle_phase_ctrl u_phase (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .run_o  (run),
    .half_o (half),
    .take_o (take),
    .req_o  (bit_req_o)
  );

  mle_bit_hold u_hold (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .din   (din),
    .half  (half),
    .bit_o (held_bit)
  );

  mle_line_reg #(
    .OUT_ON_FALL (OUT_ON_FALL)
  ) u_line (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .half   (half),
    .bit_in (held_bit),
    .line_o (line_o)
  );

  // R7: reset leaves the outputs idle
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (!bit_req_o && (OUT_ON_FALL || !line_o)));

endmodule

// File: tb/manchester_line_enc_test.sv
`timescale 1ns/1ps
module manchester_line_enc_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic din = 1'b0;
  logic line_o;
  logic bit_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  manchester_line_enc uut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .din       (din),
    .line_o    (line_o),
    .bit_req_o (bit_req_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Wait for a rising edge and settle a quarter period after it.
  task automatic edge_settle();
    @(posedge clk);
    #5;
  endtask

  // Send n bits without gaps, starting from idle; checks R1, R2, R4, R5, R8.
  task automatic send_stream(input logic [15:0] bits, input int n, input bit spoil_mid);
    en  = 1'b1;
    din = bits[0];
    edge_settle();                                // E0: bit 0 sampled
    chk("R5 line low in first enabled cycle", line_o, 1'b0);
    chk("R5 no request in first enabled cycle", bit_req_o, 1'b0);
    if (spoil_mid) din = ~bits[0];                // R3: ignored at the mid-bit edge
    for (int i = 0; i < n; i++) begin
      edge_settle();                              // E0+2i+1
      chk(bits[i] ? "R2 first half low" : "R1 first half high", line_o, ~bits[i]);
      chk("R4 request with first half", bit_req_o, 1'b1);
      din = (i + 1 < n) ? bits[i+1] : 1'b0;
      edge_settle();                              // E0+2i+2
      chk(bits[i] ? "R2 second half high" : "R8 R1 second half low", line_o, bits[i]);
      chk("R4 request single cycle", bit_req_o, 1'b0);
      if (spoil_mid && i + 1 < n) din = ~bits[i+1];
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b0;
    edge_settle();
    edge_settle();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 reset line", line_o, 1'b0);
    chk("R7 reset request", bit_req_o, 1'b0);
  endtask

  task automatic t_disable();
    en = 1'b1; din = 1'b1;
    edge_settle();                                // E0
    edge_settle();                                // first half of a 1: low
    edge_settle();                                // second half: high
    chk("R2 second half before disable", line_o, 1'b1);
    en = 1'b0;
    edge_settle();                                // en seen low
    chk("R6 request cleared", bit_req_o, 1'b0);
    edge_settle();
    chk("R6 line idle low", line_o, 1'b0);
    chk("R6 request stays low", bit_req_o, 1'b0);
    edge_settle();
    chk("R6 line remains low", line_o, 1'b0);
  endtask

  task automatic t_reset_mid();
    en = 1'b1; din = 1'b0;
    edge_settle();
    edge_settle();                                // first half of 0: high
    chk("R1 first half before reset", line_o, 1'b1);
    rst = 1'b1;
    edge_settle();
    chk("R7 mid-stream reset line", line_o, 1'b0);
    chk("R7 mid-stream reset request", bit_req_o, 1'b0);
    rst = 1'b0;
    en  = 1'b0;
    edge_settle();
    // After reset the held bit is 0; a fresh 1 must still be encoded correctly.
  endtask

  initial begin
    do_reset();
    t_reset();
    send_stream(16'b0000_0000_0000_0000, 3, 1'b0);
    en = 1'b0; edge_settle(); edge_settle();
    send_stream(16'b0000_0000_0000_0111, 4, 1'b0);
    en = 1'b0; edge_settle(); edge_settle();
    send_stream(16'b0000_0000_0101_1010, 8, 1'b0);
    en = 1'b0; edge_settle(); edge_settle();
    send_stream(16'b0000_0000_0011_0100, 6, 1'b1); // R3 mid-bit changes
    en = 1'b0; edge_settle(); edge_settle();
    t_disable();
    t_reset_mid();
    send_stream(16'b0000_0000_0000_0001, 2, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule